// File: doc/BRIEF.md
# Selectable Decade/Binary Prescaler

This block turns one of four selectable base rates into four successively slower tick strobes that counter channels use as internal count sources. The base rates are made inside the block by dividing the system clock by four fixed, parameter-set ratios. A 2-bit select picks one of them. A single mode bit then decides whether the four taps step down by factors of ten or by factors of sixteen.

The scaling chain is a cascade of identical digit stages. In decimal mode each stage counts modulo 10, and in binary mode modulo 16. A stage advances only when every stage below it wraps on the same base tick. Each tap is a registered strobe, one system clock wide, raised when its stage and all lower stages wrap together. Any change of the select or of the mode clears the whole chain synchronously, so no tap ever emits a shortened period.

Top module: `decscale_prescaler`

## Requirements
- R1: While rst_n is low, and on the first cycle after it is released, every bit of tap_o is 0. Reset leaves the base divider and all stages at zero.
- R2: src_sel picks the base tick period in system clocks. The encoding is 0 → DIV_SEL0, 1 → DIV_SEL1, 2 → DIV_SEL2 and 3 → DIV_SEL3. The defaults are 10, 2, 10 and 20.
- R3: With bcd_mode = 1, tap_o[k] (k = 0..3) pulses every 10^(k+1) base ticks.
- R4: With bcd_mode = 0, tap_o[k] pulses every 16^(k+1) base ticks.
- R5: Each tap_o bit is high for exactly one system clock per pulse and is never high on two consecutive cycles.
- R6: tap_o[k] is high only in a cycle where tap_o[k-1] is also high, for k = 1..3.
- R7: A change of src_sel or bcd_mode clears the base divider and all stages at the clock edge that samples the change. tap_o is 0 after that edge. The first tap_o[k] pulse then appears exactly one full period, D·R^(k+1) system clocks, later.
- R8: After reset or after a clear, and with the configuration held, tap_o[k] is high exactly after clock edges n = m·D·R^(k+1) (m ≥ 1), counting n from the reset/clear state. D is the selected divisor, and R is 10 in decimal mode and 16 in binary mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | Base rate select (0..3) |
| bcd_mode | input | 1 | 1 = decimal steps, 0 = binary steps |
| tap_o | output | NUM_TAPS | Single-cycle tick strobes, tap 0 fastest |

## Verification
The chain is exercised in both modes across all four source selects. Each run is long enough that the slowest tap it reaches wraps at least once. Matching the fastest divisor against the slowest one shows whether the select encoding and the divider limits are right. Binary runs with the fastest source reach the 65536 tap and show that the modulus truly switches, rather than a decimal chain being reused. Mid-period changes of the select and of the mode, a change followed quickly by a change back, and a reset in the middle of a run show whether the clear is complete and whether the next pulse arrives a full period later.

// File: rtl/ps_pkg.sv
package ps_pkg;

    localparam int DIGIT_W = 4;
    localparam int BCD_TOP = 9;
    localparam int BIN_TOP = 15;

    typedef struct packed {
        logic [1:0] sel;
        logic       bcd;
    } ps_cfg_t;

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/ps_base_div.sv
module ps_base_div #(
    parameter int DIV_SEL0 = 10,
    parameter int DIV_SEL1 = 2,
    parameter int DIV_SEL2 = 10,
    parameter int DIV_SEL3 = 20,
    parameter int CNT_W    = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic [1:0] sel,
    output logic       base_tick
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_state_t;

    div_state_t       st_d, st_q;
    logic [CNT_W-1:0] last_cnt;

    always_comb begin
        unique case (sel)
            2'd0:    last_cnt = CNT_W'(DIV_SEL0 - 1);
            2'd1:    last_cnt = CNT_W'(DIV_SEL1 - 1);
            2'd2:    last_cnt = CNT_W'(DIV_SEL2 - 1);
            default: last_cnt = CNT_W'(DIV_SEL3 - 1);
        endcase

        st_d      = st_q;
        base_tick = 1'b0;
        if (clr) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == last_cnt) begin
            st_d.cnt  = '0;
            base_tick = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/ps_digit_stage.sv
module ps_digit_stage
    import ps_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic bcd,
    input  logic carry_in,
    output logic carry_out
);

    logic [DIGIT_W-1:0] digit_d, digit_q;
    logic               at_top;

    always_comb begin
        at_top    = (digit_q == (bcd ? DIGIT_W'(BCD_TOP) : DIGIT_W'(BIN_TOP)));
        carry_out = carry_in & at_top;
        digit_d   = digit_q;
        if (clr)           digit_d = '0;
        else if (carry_in) digit_d = at_top ? '0 : digit_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) digit_q <= '0;
        else        digit_q <= digit_d;
    end

endmodule

// File: rtl/decscale_prescaler.sv
module decscale_prescaler
    import ps_pkg::*;
#(
    parameter int NUM_TAPS = 4,
    parameter int DIV_SEL0 = 10,
    parameter int DIV_SEL1 = 2,
    parameter int DIV_SEL2 = 10,
    parameter int DIV_SEL3 = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          src_sel,
    input  logic                bcd_mode,
    output logic [NUM_TAPS-1:0] tap_o
);

    localparam int DIV_MAX = max_of4(DIV_SEL0, DIV_SEL1, DIV_SEL2, DIV_SEL3);
    localparam int CNT_W   = $clog2(DIV_MAX + 1);

    typedef struct packed {
        ps_cfg_t             cfg;
        logic [NUM_TAPS-1:0] taps;
    } top_state_t;

    top_state_t          st_d, st_q;
    ps_cfg_t             cfg_in;
    logic                clr;
    logic                base_tick;
    logic [NUM_TAPS:0]   carry;

    always_comb begin
        cfg_in.sel = src_sel;
        cfg_in.bcd = bcd_mode;
        clr        = (cfg_in != st_q.cfg);
    end

    ps_base_div #(
        .DIV_SEL0 (DIV_SEL0),
        .DIV_SEL1 (DIV_SEL1),
        .DIV_SEL2 (DIV_SEL2),
        .DIV_SEL3 (DIV_SEL3),
        .CNT_W    (CNT_W)
    ) u_base (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .sel       (src_sel),
        .base_tick (base_tick)
    );

    assign carry[0] = base_tick;

    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_stage
        ps_digit_stage u_stage (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (clr),
            .bcd       (bcd_mode),
            .carry_in  (carry[g]),
            .carry_out (carry[g+1])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.cfg = cfg_in;
        if (clr) st_d.taps = '0;
        else     st_d.taps = carry[NUM_TAPS:1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tap_o = st_q.taps;

endmodule

// File: rtl/ps_prescaler_chk.sv
module ps_prescaler_chk #(
    parameter int NUM_TAPS = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          src_sel,
    input logic                bcd_mode,
    input logic [NUM_TAPS-1:0] tap_o
);

    // R1: taps are quiet on the first sampled edge after reset release
    p_reset_quiet_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (tap_o == '0));

    // R5: no tap is high on two consecutive cycles
    p_strobe_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((tap_o & $past(tap_o)) == '0));

    // R6: a slower tap fires only together with the next faster one
    p_nested_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((tap_o & ~{tap_o[NUM_TAPS-2:0], 1'b1}) == '0));

    // R7: a configuration change leaves all taps cleared after that edge
    p_cfg_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_sel != $past(src_sel)) || (bcd_mode != $past(bcd_mode)))
        |=> (tap_o == '0));

endmodule

bind decscale_prescaler ps_prescaler_chk #(.NUM_TAPS(NUM_TAPS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_sel  (src_sel),
    .bcd_mode (bcd_mode),
    .tap_o    (tap_o)
);

// File: tb/tb_decscale_prescaler.sv
module tb_decscale_prescaler;

    localparam int CLK_PERIOD = 10;
    localparam int NT = 4;
    localparam int D0 = 1;
    localparam int D1 = 2;
    localparam int D2 = 3;
    localparam int D3 = 5;

    typedef struct {
        logic [NT-1:0] exp;
        string         req;
    } sb_item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    src_sel = 2'd0;
    logic          bcd_mode = 1'b0;
    logic [NT-1:0] tap_o;

    int vectors = 0;
    int errors  = 0;

    sb_item_t      sbq[$];
    longint        n_edges = 0;
    logic [2:0]    last_cfg = 3'b000;
    logic [NT-1:0] prev_tap = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    decscale_prescaler #(
        .NUM_TAPS (NT),
        .DIV_SEL0 (D0),
        .DIV_SEL1 (D1),
        .DIV_SEL2 (D2),
        .DIV_SEL3 (D3)
    ) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_sel  (src_sel),
        .bcd_mode (bcd_mode),
        .tap_o    (tap_o)
    );

    function automatic longint sel_div(input logic [1:0] s);
        case (s)
            2'd0:    return D0;
            2'd1:    return D1;
            2'd2:    return D2;
            default: return D3;
        endcase
    endfunction

    function automatic logic [NT-1:0] model_taps(input longint n,
                                                 input logic [1:0] s,
                                                 input logic b);
        logic [NT-1:0] e;
        longint p;
        p = sel_div(s);
        for (int k = 0; k < NT; k++) begin
            p = p * (b ? 10 : 16);
            e[k] = (n > 0) && ((n % p) == 0);
        end
        return e;
    endfunction

    // Driver: advances the model on each edge and queues the expected taps
    task automatic run(input int cycles, input string req);
        sb_item_t it;
        for (int c = 0; c < cycles; c++) begin
            @(posedge clk);
            if (!rst_n) begin
                n_edges  = 0;
                last_cfg = 3'b000;
            end else if ({src_sel, bcd_mode} != last_cfg) begin
                n_edges  = 0;
                last_cfg = {src_sel, bcd_mode};
            end else begin
                n_edges++;
            end
            it.exp = model_taps(n_edges, src_sel, bcd_mode);
            it.req = req;
            sbq.push_back(it);
        end
        @(negedge clk);
    endtask

    // Monitor: pops expectations and compares half a cycle after each edge
    initial begin
        sb_item_t it;
        forever begin
            @(negedge clk);
            if (sbq.size() > 0) begin
                it = sbq.pop_front();
                vectors++;
                if (tap_o !== it.exp) begin
                    errors++;
                    $display("FAIL %s: tap_o=%b expected=%b at model edge %0d",
                             it.req, tap_o, it.exp, n_edges);
                end
                if (tap_o != '0) begin
                    vectors++;
                    if ((tap_o & prev_tap) != '0) begin   // R5
                        errors++;
                        $display("FAIL R5: tap_o=%b after %b expected no overlap",
                                 tap_o, prev_tap);
                    end
                    vectors++;
                    if ((tap_o & ~{tap_o[NT-2:0], 1'b1}) != '0) begin   // R6
                        errors++;
                        $display("FAIL R6: tap_o=%b expected nested pulses", tap_o);
                    end
                end
                prev_tap = tap_o;
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        $display("FAIL watchdog: run incomplete, expected finish before timeout");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        run(3, "R1");
        rst_n = 1'b1;
        run(4, "R1");
        // decimal, fastest source: tap3 every 10000 clocks
        bcd_mode = 1'b1; src_sel = 2'd0;
        run(25000, "R3 R8");
        // decimal, slowest source: tap2 every 5000 clocks
        src_sel = 2'd3;
        run(6000, "R2 R3");
        // decimal, divide by 2
        src_sel = 2'd1;
        run(2500, "R2 R3");
        // binary, fastest source reaches the 65536 tap
        bcd_mode = 1'b0; src_sel = 2'd0;
        run(70000, "R4 R8");
        // binary, divide by 3: tap2 every 12288 clocks
        src_sel = 2'd2;
        run(13000, "R2 R4");
        // mid-period select change
        src_sel = 2'd0;
        run(37, "R7");
        src_sel = 2'd1;
        run(700, "R7");
        // mid-period mode change
        bcd_mode = 1'b1;
        run(13, "R7");
        bcd_mode = 1'b0;
        run(1, "R7");
        bcd_mode = 1'b1;
        run(450, "R7");
        // reset in the middle of a run
        rst_n = 1'b0;
        run(2, "R1");
        rst_n = 1'b1;
        run(2100, "R1 R8");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule